// File: doc/BRIEF.md
# Relocatable Memory Map Priority Decoder

This block turns a 16-bit processor address into one chip select among four targets: the on-chip ROM, a 256-byte on-chip RAM, a 64-byte on-chip register file, and the external bus. The RAM and the register file can each be moved to the start of any 4 KB page. Software supplies the page number for each as a 4-bit value. The ROM sits in a fixed window at the top of the map and is used only while its enable input is high.

Two regions may be mapped onto the same addresses. When that happens, a fixed ranking picks the winner: the register file first, then the RAM, then the ROM. Every address in the 64-byte register window counts as register space, including offsets where no register exists, so a read there returns the undriven internal bus. In expanded mode, six offsets of the register window are passed to the external bus. This lets an external port-replacement device answer for them.

The block is purely combinational. It has no internal state. Its only other output, `ext_ignore`, tells the data path to discard whatever is on the external data pins because an internal resource is supplying the data.

Top module: `mmap_decoder`

## Requirements
- R1: With the default page values (RAM page 0x0, register page 0x1), addresses 0x0000–0x00FF assert `sel_ram` and addresses 0x1000–0x103F assert `sel_reg`.
- R2: A page value P places the RAM at P·0x1000 through P·0x1000+0xFF and the register file at P·0x1000 through P·0x1000+0x3F. The address one past each window does not select that resource. For example, RAM page 0x0 with register page 0xC puts the registers at 0xC000.
- R3: The register window has the highest priority. Inside it, `sel_ram` and `sel_rom` are 0 even when the RAM or ROM window also covers the address.
- R4: RAM outranks ROM. With ROM enabled and both pages at 0xF, 0xF000–0xF03F selects registers, 0xF040–0xF0FF selects RAM, and 0xF100–0xFFFF selects ROM.
- R5: ROM covers 0xE000–0xFFFF and is selected there only when `rom_en` is 1. With `rom_en` at 0, those addresses fall through to the external bus or to no select.
- R6: In expanded mode (`expanded`=1), register-window offsets 0x02 through 0x07 assert `sel_ext` with `sel_reg`, `sel_ram` and `sel_rom` all 0. In single-chip mode the same offsets assert `sel_reg`.
- R7: All 64 offsets of the register window select `sel_reg`, including offsets with no register behind them, except the R6 offsets in expanded mode.
- R8: An address outside every internal window selects `sel_ext` in expanded mode and asserts no select in single-chip mode.
- R9: `ext_ignore` is 1 exactly when `sel_rom`, `sel_ram` or `sel_reg` is 1.
- R10: At most one select is active for any input. In expanded mode exactly one is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 16 | Processor address |
| ram_page | input | 4 | Page number (top hex digit) of the RAM base |
| reg_page | input | 4 | Page number (top hex digit) of the register file base |
| rom_en | input | 1 | ROM window enabled |
| expanded | input | 1 | 1 = expanded mode, 0 = single-chip mode |
| sel_rom | output | 1 | ROM chip select |
| sel_ram | output | 1 | RAM chip select |
| sel_reg | output | 1 | Register file chip select |
| sel_ext | output | 1 | External bus cycle |
| ext_ignore | output | 1 | Discard external data pins this access |

## Verification
The bench builds the decoder with its default parameters:
- a 16-bit address,
- 4-bit page numbers,
- a 0xE000 ROM start,
- a forwarded-offset range of 0x02–0x07.

With these defaults, every page placement and every overlap case is reachable with a handful of page values. Each directed scenario also sweeps the whole address space in steps. The sweep crosses both edges of every window against a reference decode built from the requirements. This covers stacked windows at 0xF000, windows inside the ROM range with ROM disabled, and the forwarded offsets in both modes.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_REG,
        TGT_RAM,
        TGT_ROM,
        TGT_EXT
    } target_e;
endpackage

// File: rtl/mmap_window_match.sv
module mmap_window_match #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 4,
    parameter int SPAN_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [PAGE_W-1:0] page,
    output logic              hit
);
    localparam int GAP_W = ADDR_W - PAGE_W - SPAN_W;

    logic page_eq;
    logic gap_zero;

    always_comb begin
        page_eq  = (addr[ADDR_W-1 -: PAGE_W] == page);
        gap_zero = (addr[SPAN_W +: GAP_W] == '0);
        hit      = page_eq && gap_zero;
    end
endmodule

// File: rtl/mmap_ext_hole.sv
module mmap_ext_hole #(
    parameter int SPAN_W  = 6,
    parameter int HOLE_LO = 2,
    parameter int HOLE_HI = 7
) (
    input  logic [SPAN_W-1:0] offset,
    input  logic              reg_hit,
    input  logic              expanded,
    output logic              hole
);
    localparam logic [SPAN_W-1:0] LO = SPAN_W'(HOLE_LO);
    localparam logic [SPAN_W-1:0] HI = SPAN_W'(HOLE_HI);

    logic in_range;

    always_comb begin
        in_range = (offset >= LO) && (offset <= HI);
        hole     = reg_hit && expanded && in_range;
    end
endmodule

// File: rtl/mmap_priority.sv
module mmap_priority
    import mmap_pkg::*;
(
    input  logic reg_hit,
    input  logic ram_hit,
    input  logic rom_hit,
    input  logic hole,
    input  logic expanded,
    output logic sel_rom,
    output logic sel_ram,
    output logic sel_reg,
    output logic sel_ext,
    output logic ext_ignore
);
    target_e tgt;

    always_comb begin
        if (hole)              tgt = TGT_EXT;
        else if (reg_hit)      tgt = TGT_REG;
        else if (ram_hit)      tgt = TGT_RAM;
        else if (rom_hit)      tgt = TGT_ROM;
        else if (expanded)     tgt = TGT_EXT;
        else                   tgt = TGT_NONE;
    end

    always_comb begin
        sel_rom = 1'b0;
        sel_ram = 1'b0;
        sel_reg = 1'b0;
        sel_ext = 1'b0;
        unique case (tgt)
            TGT_REG:  sel_reg = 1'b1;
            TGT_RAM:  sel_ram = 1'b1;
            TGT_ROM:  sel_rom = 1'b1;
            TGT_EXT:  sel_ext = 1'b1;
            default:  ;
        endcase
        ext_ignore = sel_rom | sel_ram | sel_reg;

        // R10
        one_select_chk: assert ($countones({sel_rom, sel_ram, sel_reg, sel_ext}) <= 1);
        // R10
        exp_select_chk: assert (!expanded || ($countones({sel_rom, sel_ram, sel_reg, sel_ext}) == 1));
        // R3
        reg_wins_chk: assert (!(reg_hit && !hole) || (sel_reg && !sel_ram && !sel_rom));
        // R4
        ram_over_rom_chk: assert (!(ram_hit && rom_hit && !reg_hit) || (sel_ram && !sel_rom));
        // R6
        hole_ext_chk: assert (!hole || (sel_ext && !ext_ignore));
        // R9
        ignore_chk: assert (ext_ignore == !(sel_ext || (!expanded && !reg_hit && !ram_hit && !rom_hit)));
    end
endmodule

// File: rtl/mmap_decoder.sv
module mmap_decoder #(
    parameter int ADDR_W     = 16,
    parameter int PAGE_W     = 4,
    parameter int RAM_SPAN_W = 8,
    parameter int REG_SPAN_W = 6,
    parameter int ROM_START  = 16'hE000,
    parameter int HOLE_LO    = 2,
    parameter int HOLE_HI    = 7
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [PAGE_W-1:0] ram_page,
    input  logic [PAGE_W-1:0] reg_page,
    input  logic              rom_en,
    input  logic              expanded,
    output logic              sel_rom,
    output logic              sel_ram,
    output logic              sel_reg,
    output logic              sel_ext,
    output logic              ext_ignore
);
    localparam logic [ADDR_W-1:0] ROM_LO = ADDR_W'(ROM_START);

    logic ram_hit;
    logic reg_hit;
    logic rom_hit;
    logic hole;

    mmap_window_match #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W),
        .SPAN_W (RAM_SPAN_W)
    ) u_ram_win (
        .addr (addr),
        .page (ram_page),
        .hit  (ram_hit)
    );

    mmap_window_match #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W),
        .SPAN_W (REG_SPAN_W)
    ) u_reg_win (
        .addr (addr),
        .page (reg_page),
        .hit  (reg_hit)
    );

    always_comb begin
        rom_hit = rom_en && (addr >= ROM_LO);
    end

    mmap_ext_hole #(
        .SPAN_W  (REG_SPAN_W),
        .HOLE_LO (HOLE_LO),
        .HOLE_HI (HOLE_HI)
    ) u_hole (
        .offset   (addr[REG_SPAN_W-1:0]),
        .reg_hit  (reg_hit),
        .expanded (expanded),
        .hole     (hole)
    );

    mmap_priority u_prio (
        .reg_hit    (reg_hit),
        .ram_hit    (ram_hit),
        .rom_hit    (rom_hit),
        .hole       (hole),
        .expanded   (expanded),
        .sel_rom    (sel_rom),
        .sel_ram    (sel_ram),
        .sel_reg    (sel_reg),
        .sel_ext    (sel_ext),
        .ext_ignore (ext_ignore)
    );
endmodule

// File: tb/tb_mmap_decoder.sv
module tb_mmap_decoder;
    logic        clk = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic [3:0]  ram_page = 4'h0;
    logic [3:0]  reg_page = 4'h1;
    logic        rom_en = 1'b0;
    logic        expanded = 1'b0;
    logic        sel_rom, sel_ram, sel_reg, sel_ext, ext_ignore;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    mmap_decoder dut (
        .addr       (addr),
        .ram_page   (ram_page),
        .reg_page   (reg_page),
        .rom_en     (rom_en),
        .expanded   (expanded),
        .sel_rom    (sel_rom),
        .sel_ram    (sel_ram),
        .sel_reg    (sel_reg),
        .sel_ext    (sel_ext),
        .ext_ignore (ext_ignore)
    );

    // reference decode from the requirements: {rom, ram, reg, ext}
    function automatic logic [3:0] ref_sel(input logic [15:0] a, input logic [3:0] rp,
                                           input logic [3:0] gp, input logic re, input logic ex);
        logic in_reg, in_ram, in_rom, fwd;
        in_reg = (a[15:12] == gp) && (a[11:0] < 12'h040);
        in_ram = (a[15:12] == rp) && (a[11:0] < 12'h100);
        in_rom = re && (a >= 16'hE000);
        fwd    = ex && in_reg && (a[5:0] >= 6'd2) && (a[5:0] <= 6'd7);
        if (fwd)         return 4'b0001;
        else if (in_reg) return 4'b0010;
        else if (in_ram) return 4'b0100;
        else if (in_rom) return 4'b1000;
        else if (ex)     return 4'b0001;
        else             return 4'b0000;
    endfunction

    task automatic probe(input logic [15:0] a, input logic [3:0] exp_sel, input string req);
        logic [3:0] got;
        logic exp_ign;
        addr = a;
        #2;
        got = {sel_rom, sel_ram, sel_reg, sel_ext};
        exp_ign = |exp_sel[3:1];
        total++;
        if (got !== exp_sel || ext_ignore !== exp_ign) begin
            bad++;
            $display("FAIL %s addr=%h sel(rom,ram,reg,ext)=%b ign=%b expected %b ign=%b",
                     req, a, got, ext_ignore, exp_sel, exp_ign);
        end
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < 65536; i += 61) begin
            probe(16'(i), ref_sel(16'(i), ram_page, reg_page, rom_en, expanded), req);
        end
    endtask

    task automatic set_cfg(input logic [3:0] rp, input logic [3:0] gp, input logic re, input logic ex);
        @(negedge clk);
        ram_page = rp; reg_page = gp; rom_en = re; expanded = ex;
    endtask

    task automatic t_defaults;
        set_cfg(4'h0, 4'h1, 1'b0, 1'b0);
        probe(16'h0000, 4'b0100, "R1");
        probe(16'h00FF, 4'b0100, "R1");
        probe(16'h0100, 4'b0000, "R1");
        probe(16'h1000, 4'b0010, "R1");
        probe(16'h103F, 4'b0010, "R1");
        probe(16'h1040, 4'b0000, "R1");
        sweep("R1");
    endtask

    task automatic t_relocate;
        set_cfg(4'h0, 4'hC, 1'b0, 1'b0);
        probe(16'hC000, 4'b0010, "R2");
        probe(16'h1000, 4'b0000, "R2");
        set_cfg(4'h7, 4'h3, 1'b0, 1'b0);
        probe(16'h7080, 4'b0100, "R2");
        probe(16'h7100, 4'b0000, "R2");
        probe(16'h303F, 4'b0010, "R2");
        probe(16'h3040, 4'b0000, "R2");
        sweep("R2");
    endtask

    task automatic t_stack;
        set_cfg(4'hF, 4'hF, 1'b1, 1'b0);
        probe(16'hF000, 4'b0010, "R3");
        probe(16'hF03F, 4'b0010, "R3");
        probe(16'hF040, 4'b0100, "R4");
        probe(16'hF0FF, 4'b0100, "R4");
        probe(16'hF100, 4'b1000, "R4");
        probe(16'hFFFF, 4'b1000, "R4");
        sweep("R3");
    endtask

    task automatic t_rom;
        set_cfg(4'h0, 4'h1, 1'b1, 1'b0);
        probe(16'hE000, 4'b1000, "R5");
        probe(16'hDFFF, 4'b0000, "R5");
        set_cfg(4'h0, 4'h1, 1'b0, 1'b1);
        probe(16'hE000, 4'b0001, "R5");
        set_cfg(4'h0, 4'h1, 1'b0, 1'b0);
        probe(16'hFFFE, 4'b0000, "R5");
    endtask

    task automatic t_holes;
        set_cfg(4'hF, 4'hF, 1'b1, 1'b1);
        probe(16'hF001, 4'b0010, "R6");
        probe(16'hF002, 4'b0001, "R6");
        probe(16'hF007, 4'b0001, "R6");
        probe(16'hF008, 4'b0010, "R6");
        set_cfg(4'h0, 4'h1, 1'b0, 1'b0);
        probe(16'h1004, 4'b0010, "R6");
        set_cfg(4'h0, 4'h1, 1'b0, 1'b1);
        for (int o = 0; o < 64; o++) begin
            probe(16'h1000 + 16'(o), ((o >= 2) && (o <= 7)) ? 4'b0001 : 4'b0010, "R7");
        end
        sweep("R6");
    endtask

    task automatic t_unmatched;
        set_cfg(4'h0, 4'h1, 1'b1, 1'b1);
        probe(16'h5555, 4'b0001, "R8");
        probe(16'h1040, 4'b0001, "R8");
        set_cfg(4'h0, 4'h1, 1'b1, 1'b0);
        probe(16'h5555, 4'b0000, "R8");
        sweep("R9");
        set_cfg(4'h2, 4'h2, 1'b1, 1'b1);
        sweep("R10");
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung, cycles=%0d expected below 150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #3;
        // state after power-up defaults (no internal state)
        total++;
        if ({sel_rom, sel_ram, sel_reg, sel_ext, ext_ignore} !== 5'b01001) begin
            bad++;
            $display("FAIL R1 initial sel=%b expected 01001",
                     {sel_rom, sel_ram, sel_reg, sel_ext, ext_ignore});
        end
        t_defaults();
        t_relocate();
        t_stack();
        t_rom();
        t_holes();
        t_unmatched();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule